// File: doc/BRIEF.md
# Cascadable Segment Data Loader

This block captures one display line of pixel codes for up to 120 segment outputs of a dot-matrix LCD driver and holds it for the output stage. Pixel data arrives on a 4-bit port clocked by a shift clock. In parallel mode each clock carries a whole nibble. In serial mode only bit 0 carries data. A format select chooses 1-bit (black-and-white), 2-bit (4-level) or 4-bit (16-level) pixels. A direction select picks the fill order and decides which of the two cascade enable pins is the input and which is the output.

Loading starts when the incoming cascade enable is seen. The loader counts its own data clocks from the segment count, the format and the bus mode. After the last data clock it stops accepting data and sends a one-clock enable pulse to the next chip in the chain. From then on it ignores data and enables until a latch pulse. The latch pulse copies the line buffer into the output latch and rearms the loader for the next line. A display-off input blanks the output latch. When some outputs of the chip serve as commons, the segment count is reduced and only the segment side of the outputs is filled.

Top module: `seg_line_loader`

## Requirements
- R1: After reset every output pixel code (`line_o`) is zero and both cascade enable outputs are low.
- R2: In parallel mode with `fmt`=0 (black-and-white), each accepted clock loads four consecutive pixels, with `din[j]` going to the j-th pixel of the group. Codes 0/1 are stored in bit 0 of the 4-bit code. A 120-segment line takes 30 clocks. `fmt`=3 behaves like `fmt`=0.
- R3: In parallel mode with `fmt`=1 (4-level), each clock loads two pixels: `din[1:0]` goes to the earlier pixel and `din[3:2]` to the later one, the higher bit being the MSB. A 120-segment line takes 60 clocks.
- R4: In parallel mode with `fmt`=2 (16-level), each clock loads one 4-bit pixel from `din[3:0]`. A 120-segment line takes 120 clocks.
- R5: In serial mode (`par_mode`=0) only `din[0]` is used and each pixel is sent LSB first. A line takes segments × 1, 2 or 4 clocks for the three formats.
- R6: With `dir_fwd`=1 the pixels fill Y0 upward, `en_a_i` is the enable input and `en_b_o` the enable output. With `dir_fwd`=0 they fill Y119 downward, `en_b_i` is the input and `en_a_o` the output. An enable on the unused input pin has no effect.
- R7: `seg_mode` sets the segment count: 0→120, 1→88, 2→72, 3→56, 4→40, 5→24, 6→8, 7→0. With a count of zero, a seen enable is passed on after one clock and no data is loaded. Outputs outside the segment range keep their previous codes.
- R8: On the clock that captures the last pixel bit, the loader stops. The outgoing enable is high for exactly the following clock. Later data and enables are ignored until a latch pulse.
- R9: While waiting for its enable, the loader ignores the data port.
- R10: A latch pulse copies the line buffer into `line_o` on the next clock and resets the load position, even in the middle of a line. Data on the latch clock is not loaded.
- R11: While `disp_off` is high, `line_o` is forced to zero, including on a latch pulse. The line buffer is unaffected and appears again at the next latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low reset |
| par_mode | input | 1 | 1: nibble-parallel data, 0: serial on din[0] |
| fmt | input | 2 | Pixel format: 0 b/w, 1 4-level, 2 16-level, 3 as 0 |
| dir_fwd | input | 1 | Fill direction and cascade pin roles |
| seg_mode | input | 3 | Segment count select |
| din | input | 4 | Pixel data |
| en_a_i | input | 1 | Cascade enable in, used when dir_fwd=1 |
| en_b_i | input | 1 | Cascade enable in, used when dir_fwd=0 |
| latch | input | 1 | Line latch pulse |
| disp_off | input | 1 | Blank the output latch |
| en_a_o | output | 1 | Cascade enable out, used when dir_fwd=0 |
| en_b_o | output | 1 | Cascade enable out, used when dir_fwd=1 |
| line_o | output | 480 | Latched 4-bit code per output, Y p at bits [4p+3:4p] |

## Verification
The hardest situation to reach is the stop boundary. It is the one clock where the final bit lands, the outgoing pulse starts, and a stray enable with data arrives right after. It has to be hit for every combination of bus mode, format, direction and segment count, because the clock count comes from all four. The bench sweeps every one of those combinations. It drives exactly the computed number of clocks, watches that the pulse does not appear early, and then adds a clock with enable and junk data. It also places an enable on the unused pin before each line. Separate sequences latch in the middle of a line and toggle display-off around a latch.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_DONE = 2'd2
    } ld_state_e;

    // bits carried by one pixel for a format code
    function automatic logic [2:0] bpp_of(input logic [1:0] fmt);
        case (fmt)
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // pixels carried by one parallel nibble for a format code
    function automatic logic [2:0] ppc_of(input logic [1:0] fmt);
        case (fmt)
            2'd1:    return 3'd2;
            2'd2:    return 3'd1;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/seg_ld_seq.sv
module seg_ld_seq
    import seg_loader_pkg::*;
#(
    parameter int NSEG = 120,
    parameter int CW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          par_mode,
    input  logic [1:0]    fmt,
    input  logic          dir_fwd,
    input  logic [2:0]    seg_mode,
    input  logic          en_a_i,
    input  logic          en_b_i,
    input  logic          latch,
    output logic          wr_en,
    output logic [CW-1:0] pix,
    output logic [1:0]    sbit,
    output logic          en_a_o,
    output logic          en_b_o
);

    typedef struct packed {
        ld_state_e     st;
        logic [CW-1:0] pix;
        logic [1:0]    sbit;
        logic          en_out;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic [CW-1:0] nseg;
    logic [2:0]    bpp, ppc;
    logic          en_in, take;
    logic [CW-1:0] pix_n;
    logic [1:0]    sbit_n;

    always_comb begin
        case (seg_mode)
            3'd0:    nseg = CW'(NSEG);
            3'd7:    nseg = '0;
            default: nseg = CW'(NSEG - 16) - CW'({seg_mode, 4'b0000});
        endcase
    end

    always_comb begin
        bpp    = bpp_of(fmt);
        ppc    = ppc_of(fmt);
        en_in  = dir_fwd ? en_a_i : en_b_i;
        seq_d  = seq_q;
        seq_d.en_out = 1'b0;
        wr_en  = 1'b0;
        take   = 1'b0;
        pix_n  = seq_q.pix;
        sbit_n = seq_q.sbit;
        if (latch) begin
            seq_d.st   = ST_IDLE;
            seq_d.pix  = '0;
            seq_d.sbit = '0;
        end else begin
            take = (seq_q.st == ST_LOAD) || ((seq_q.st == ST_IDLE) && en_in);
            if (take) begin
                if (nseg == '0) begin
                    seq_d.st     = ST_DONE;
                    seq_d.en_out = 1'b1;
                end else begin
                    wr_en = 1'b1;
                    if (par_mode) begin
                        pix_n = seq_q.pix + CW'(ppc);
                    end else if ({1'b0, seq_q.sbit} == bpp - 3'd1) begin
                        sbit_n = 2'd0;
                        pix_n  = seq_q.pix + CW'(1);
                    end else begin
                        sbit_n = seq_q.sbit + 2'd1;
                    end
                    seq_d.pix  = pix_n;
                    seq_d.sbit = sbit_n;
                    if (pix_n >= nseg) begin
                        seq_d.st     = ST_DONE;
                        seq_d.en_out = 1'b1;
                    end else begin
                        seq_d.st = ST_LOAD;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pix    = seq_q.pix;
    assign sbit   = seq_q.sbit;
    assign en_a_o = seq_q.en_out & ~dir_fwd;
    assign en_b_o = seq_q.en_out &  dir_fwd;

    AST_EN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.en_out |=> !seq_q.en_out); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (seq_q.pix < nseg)); // R8
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_DONE) && !latch) |=> (seq_q.st == ST_DONE)); // R8
    AST_LATCH_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> ((seq_q.pix == '0) && (seq_q.st == ST_IDLE))); // R10

endmodule

// File: rtl/seg_ld_buf.sv
module seg_ld_buf
    import seg_loader_pkg::*;
#(
    parameter int NSEG = 120,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            par_mode,
    input  logic            dir_fwd,
    input  logic [1:0]      fmt,
    input  logic [CW-1:0]   pix,
    input  logic [1:0]      sbit,
    input  logic [3:0]      din,
    output logic [NSEG*4-1:0] buf_o
);

    logic [2:0] bpp, ppc;

    always_comb begin
        bpp = bpp_of(fmt);
        ppc = ppc_of(fmt);
    end

    for (genvar p = 0; p < NSEG; p++) begin : g_px
        localparam logic [CW-1:0] L_FWD = CW'(p);
        localparam logic [CW-1:0] L_REV = CW'(NSEG - 1 - p);

        logic [3:0]    px_d, px_q;
        logic [CW-1:0] lidx, off;
        logic [1:0]    sh;
        logic [3:0]    shifted, pval;
        logic          hit;

        always_comb begin
            lidx    = dir_fwd ? L_FWD : L_REV;
            off     = lidx - pix;
            sh      = 2'd0;
            shifted = din;
            hit     = 1'b0;
            pval    = px_q;
            if (par_mode) begin
                case (bpp)
                    3'd1:    sh = off[1:0];
                    3'd2:    sh = {off[0], 1'b0};
                    default: sh = 2'd0;
                endcase
                shifted = din >> sh;
                hit     = (lidx >= pix) && (off < CW'(ppc));
                case (bpp)
                    3'd1:    pval = {3'b000, shifted[0]};
                    3'd2:    pval = {2'b00, shifted[1:0]};
                    default: pval = shifted;
                endcase
            end else begin
                hit  = (lidx == pix);
                pval = (sbit == 2'd0) ? {3'b000, din[0]}
                                      : (px_q | (4'(din[0]) << sbit));
            end
            px_d = (wr_en && hit) ? pval : px_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) px_q <= '0;
            else        px_q <= px_d;
        end

        assign buf_o[p*4 +: 4] = px_q;
    end

    AST_BUF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(buf_o)); // R9

endmodule

// File: rtl/seg_ld_latch.sv
module seg_ld_latch #(
    parameter int NSEG = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch,
    input  logic              disp_off,
    input  logic [NSEG*4-1:0] buf_i,
    output logic [NSEG*4-1:0] line_o
);

    logic [NSEG*4-1:0] line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (disp_off)   line_d = '0;
        else if (latch) line_d = buf_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign line_o = line_q;

    AST_DISPOFF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        disp_off |=> (line_q == '0)); // R11
    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && !disp_off) |=> (line_q == $past(buf_i))); // R10

endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader #(
    parameter int NSEG = 120,
    localparam int CW  = $clog2(NSEG + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_mode,
    input  logic [1:0]        fmt,
    input  logic              dir_fwd,
    input  logic [2:0]        seg_mode,
    input  logic [3:0]        din,
    input  logic              en_a_i,
    input  logic              en_b_i,
    input  logic              latch,
    input  logic              disp_off,
    output logic              en_a_o,
    output logic              en_b_o,
    output logic [NSEG*4-1:0] line_o
);

    logic              wr_en;
    logic [CW-1:0]     pix;
    logic [1:0]        sbit;
    logic [NSEG*4-1:0] buf_w;

    seg_ld_seq #(.NSEG(NSEG), .CW(CW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_mode (par_mode),
        .fmt      (fmt),
        .dir_fwd  (dir_fwd),
        .seg_mode (seg_mode),
        .en_a_i   (en_a_i),
        .en_b_i   (en_b_i),
        .latch    (latch),
        .wr_en    (wr_en),
        .pix      (pix),
        .sbit     (sbit),
        .en_a_o   (en_a_o),
        .en_b_o   (en_b_o)
    );

    seg_ld_buf #(.NSEG(NSEG), .CW(CW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .par_mode (par_mode),
        .dir_fwd  (dir_fwd),
        .fmt      (fmt),
        .pix      (pix),
        .sbit     (sbit),
        .din      (din),
        .buf_o    (buf_w)
    );

    seg_ld_latch #(.NSEG(NSEG)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch    (latch),
        .disp_off (disp_off),
        .buf_i    (buf_w),
        .line_o   (line_o)
    );

endmodule

// File: tb/tb_seg_line_loader.sv
`timescale 1ns/1ps
module tb_seg_line_loader;

    localparam int NS = 120;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          par_mode = 1'b0;
    logic [1:0]    fmt = 2'd0;
    logic          dir_fwd = 1'b1;
    logic [2:0]    seg_mode = 3'd0;
    logic [3:0]    din = 4'd0;
    logic          en_a_i = 1'b0, en_b_i = 1'b0;
    logic          latch = 1'b0, disp_off = 1'b0;
    logic          en_a_o, en_b_o;
    logic [NS*4-1:0] line_o;

    int n_chk = 0;
    int n_fail = 0;
    int exp_buf [NS];

    always #4 clk = ~clk;

    seg_line_loader dut (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .fmt(fmt),
        .dir_fwd(dir_fwd), .seg_mode(seg_mode), .din(din),
        .en_a_i(en_a_i), .en_b_i(en_b_i), .latch(latch), .disp_off(disp_off),
        .en_a_o(en_a_o), .en_b_o(en_b_o), .line_o(line_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [NS*4-1:0] act, input logic [NS*4-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NS*4-1:0] exp_vec();
        logic [NS*4-1:0] v = '0;
        for (int p = 0; p < NS; p++) v[p*4 +: 4] = 4'(exp_buf[p]);
        return v;
    endfunction

    function automatic int pv(int ln, int l, int b);
        int v;
        v = (l * 7 + ln * 5 + 3) ^ (l >> 3);
        return v & ((1 << b) - 1);
    endfunction

    function automatic int phys(int l, int fwd);
        return fwd ? l : NS - 1 - l;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic run_line(input int par, input int fm, input int fwd, input int md, input int ln);
        int bpp, ppc, nseg, nclk;
        bit early;
        string tag;
        bpp  = (fm == 1) ? 2 : (fm == 2) ? 4 : 1;
        ppc  = 4 / bpp;
        nseg = (md == 0) ? 120 : (md == 7) ? 0 : 104 - 16 * md;
        nclk = par ? nseg * bpp / 4 : nseg * bpp;
        tag  = !par ? "R5" : (bpp == 1) ? "R2" : (bpp == 2) ? "R3" : "R4";
        par_mode = 1'(par); fmt = 2'(fm); dir_fwd = 1'(fwd); seg_mode = 3'(md);
        // enable on the unused pin must be ignored (R6)
        din = 4'hF; en_a_i = 1'(!fwd); en_b_i = 1'(fwd);
        tick();
        early = 0;
        if (nclk == 0) begin
            din = 4'hA; en_a_i = 1'(fwd); en_b_i = 1'(!fwd);
            tick();
        end
        for (int c = 0; c < nclk; c++) begin
            logic [3:0] d;
            en_a_i = 1'(fwd && c == 0);
            en_b_i = 1'(!fwd && c == 0);
            if (par) begin
                d = '0;
                for (int j = 0; j < ppc; j++) begin
                    int l = c * ppc + j;
                    int v = pv(ln, l, bpp);
                    for (int k = 0; k < bpp; k++) d[j*bpp + k] = 1'((v >> k) & 1);
                    exp_buf[phys(l, fwd)] = v;
                end
            end else begin
                int l = c / bpp;
                int v = pv(ln, l, bpp);
                d = {3'b101, 1'((v >> (c % bpp)) & 1)};
                exp_buf[phys(l, fwd)] = v;
            end
            din = d;
            tick();
            if (c < nclk - 1 && (en_a_o || en_b_o)) early = 1;
        end
        chk(!early, tag, "enable out before last data clock (R8)", {479'b0, early}, '0);
        chk((fwd ? en_b_o : en_a_o) == 1'b1 && (fwd ? en_a_o : en_b_o) == 1'b0,
            "R8/R6", "enable out after last clock", {478'b0, en_a_o, en_b_o},
            {478'b0, 1'(!fwd), 1'(fwd)});
        // stray enable and junk after stop: ignored (R8)
        din = 4'h5; en_a_i = 1'b1; en_b_i = 1'b1;
        tick();
        en_a_i = 1'b0; en_b_i = 1'b0;
        chk(!en_a_o && !en_b_o, "R8", "pulse longer than one clock",
            {478'b0, en_a_o, en_b_o}, '0);
        latch = 1'b1; din = 4'h9;
        tick();
        latch = 1'b0;
        chk(line_o == exp_vec(), tag, $sformatf("line par=%0d fmt=%0d fwd=%0d mode=%0d (R6 R7)",
            par, fm, fwd, md), line_o, exp_vec());
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NS; p++) exp_buf[p] = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(line_o == '0 && !en_a_o && !en_b_o, "R1", "reset state", line_o, '0);

        // R9: data without enable is ignored
        par_mode = 1'b1; fmt = 2'd2; dir_fwd = 1'b1; seg_mode = 3'd0;
        for (int c = 0; c < 6; c++) begin din = 4'(c + 9); tick(); end
        chk(!en_a_o && !en_b_o, "R9", "enable out while idle", {478'b0, en_a_o, en_b_o}, '0);
        latch = 1'b1; tick(); latch = 1'b0;
        chk(line_o == exp_vec(), "R9", "idle data reached buffer", line_o, exp_vec());

        // R10: latch in the middle of a line, latch beats data
        for (int c = 0; c < 10; c++) begin
            en_a_i = 1'(c == 0); din = 4'(c + 1); exp_buf[c] = c + 1; tick();
        end
        en_a_i = 1'b0; latch = 1'b1; din = 4'hE; tick(); latch = 1'b0;
        chk(line_o == exp_vec(), "R10", "mid-line latch content", line_o, exp_vec());
        chk(!en_a_o && !en_b_o, "R10", "enable out after mid-line latch",
            {478'b0, en_a_o, en_b_o}, '0);
        run_line(1, 2, 1, 0, 77);

        // sweep every mode, format, direction and segment count
        for (int par = 0; par < 2; par++)
            for (int fm = 0; fm < 4; fm++)
                for (int fwd = 0; fwd < 2; fwd++)
                    for (int md = 0; md < 8; md++)
                        run_line(par, fm, fwd, md, par * 64 + fm * 16 + fwd * 8 + md);

        // R11: display off blanks, latch during off stays blank, buffer survives
        disp_off = 1'b1; tick();
        chk(line_o == '0, "R11", "display off blank", line_o, '0);
        latch = 1'b1; tick(); latch = 1'b0;
        chk(line_o == '0, "R11", "latch while display off", line_o, '0);
        disp_off = 1'b0; latch = 1'b1; tick(); latch = 1'b0;
        chk(line_o == exp_vec(), "R11", "buffer after display on", line_o, exp_vec());

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule